// File: doc/BRIEF.md
# IDE Bus Master DMA Engine

This block is the per-channel engine that carries a complete multi-sector disk transfer between a device-side byte stream and system memory. Software sets the engine going with an arm strobe. The drive side then issues a start request that carries a sector count and a direction. The engine works out the full byte length of the request. It pulls region descriptors one at a time through a small fetch handshake and moves one byte per cycle. It spreads the request across as many regions as it needs.

Every region supplies a start address, a byte count and a last-entry marker. The memory address moves forward one byte at a time and wraps at the installed memory size. A request that ends partway through a region leaves the rest of that region for the next request. When the region marked last runs dry, the engine drops its active state. If bytes were still owed at that point, the request ends in a failure pulse, and the drive aborts its command. It does not retry. A request made while the engine is not active fails at once and moves no data. A request that completes ends in a one-cycle done pulse.

Top module: `bmdma_engine`

## Requirements
- R1: After reset the active flag is low, and no descriptor request, memory strobe, device strobe, done or fail is asserted.
- R2: An arm pulse taken while idle sets the active flag and restarts the descriptor walk at index 0. A start taken while the flag is low gives a fail pulse in the cycle after the start edge, with no descriptor fetch and no byte moved.
- R3: A start moves sectors × SECTOR_BYTES bytes, where a sector count of 0 means 256 sectors.
- R4: A descriptor holds a start address (bit 0 forced to zero), a 16-bit byte count in which 0 stands for 65536, and a last-entry flag. In memory it is two 32-bit words: the address first, then the count in bits 15:0 and the flag in bit 31. The fetch port presents these fields separately. Entries are requested in rising index order, and the request stays high until a valid is seen.
- R5: When a region runs out while bytes are still owed and it is not the last entry, the next descriptor is fetched and the transfer goes on. A request that ends inside a region leaves the remainder for the next request.
- R6: The first address of a region is its start address modulo MEM_BYTES. Each byte advances the address by one, and the address wraps from MEM_BYTES-1 to 0.
- R7: With direction 1, each beat pops one device byte and writes it to memory in the same cycle. With direction 0, each beat reads memory and pushes that byte to the device in the same cycle.
- R8: Exhausting the last-entry region clears the active flag. If bytes are still owed at that moment, a fail pulse is given and no further byte moves.
- R9: Done and fail are one-cycle pulses and never occur together. Counting rising edges after the start edge, either pulse appears after (bytes moved + descriptors fetched) edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Sets the active flag and restarts the descriptor walk |
| start_i | input | 1 | Transfer request strobe |
| start_secs_i | input | 8 | Sector count of the request, 0 = 256 |
| start_dir_i | input | 1 | 1 = device to memory, 0 = memory to device |
| desc_req_o | output | 1 | Descriptor fetch request |
| desc_idx_o | output | IDX_W | Index of the requested descriptor |
| desc_vld_i | input | 1 | Descriptor fields valid |
| desc_base_i | input | 32 | Region start address |
| desc_cnt_i | input | 16 | Region byte count, 0 = 65536 |
| desc_eot_i | input | 1 | Last-entry flag |
| mem_we_o | output | 1 | Memory byte write strobe |
| mem_re_o | output | 1 | Memory byte read strobe |
| mem_addr_o | output | AW | Memory byte address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, same cycle |
| dev_pop_o | output | 1 | Takes one byte from the device |
| dev_rdata_i | input | 8 | Device byte presented for a pop |
| dev_push_o | output | 1 | Gives one byte to the device |
| dev_wdata_o | output | 8 | Byte given to the device |
| active_o | output | 1 | Active flag |
| done_o | output | 1 | Transfer completed pulse |
| fail_o | output | 1 | Transfer failed pulse |

## Verification
Each byte beat is checked in the cycle its strobe is high, against an address and data value that the bench derives from the descriptor table and the running byte index. The done or fail pulse is due exactly (bytes moved + descriptors fetched) edges after the start edge, because the bench's fetch model answers within one cycle. The bench counts edges from the start edge and compares that count with this sum. The active flag is read in the same cycle as the pulse. An inactive start must show its fail pulse in the first sample after the start edge.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

  typedef enum logic [1:0] {
    BM_IDLE  = 2'd0,
    BM_FETCH = 2'd1,
    BM_MOVE  = 2'd2
  } bm_state_e;

  localparam int unsigned REGION_W = 17;

  // A zero count in a descriptor stands for the largest region.
  function automatic logic [REGION_W-1:0] region_bytes(input logic [15:0] cnt);
    return (cnt == 16'd0) ? 17'h1_0000 : {1'b0, cnt};
  endfunction

endpackage

// File: rtl/bmdma_rst_sync.sv
module bmdma_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = sync_q[STAGES-1];
endmodule

// File: rtl/bmdma_region.sv
module bmdma_region
  import bmdma_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             load,
  input  logic             beat,
  input  logic [15:0]      cnt,
  input  logic             eot_in,
  output logic [IDX_W-1:0] idx,
  output logic             empty,
  output logic             last,
  output logic             eot
);
  logic [REGION_W-1:0] rem_q, rem_d;
  logic                eot_q, eot_d;
  logic [IDX_W-1:0]    idx_q, idx_d;
  logic                upd_en;

  always_comb begin
    rem_d  = rem_q;
    eot_d  = eot_q;
    idx_d  = idx_q;
    upd_en = arm | load | beat;
    if (arm) begin
      rem_d = '0;
      eot_d = 1'b0;
      idx_d = '0;
    end else if (load) begin
      rem_d = region_bytes(cnt);
      eot_d = eot_in;
      idx_d = idx_q + IDX_W'(1);
    end else if (beat) begin
      rem_d = rem_q - REGION_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      eot_q <= 1'b0;
      idx_q <= '0;
    end else if (upd_en) begin
      rem_q <= rem_d;
      eot_q <= eot_d;
      idx_q <= idx_d;
    end
  end

  assign idx   = idx_q;
  assign empty = (rem_q == '0);
  assign last  = (rem_q == REGION_W'(1));
  assign eot   = eot_q;

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    beat |-> (rem_q != '0)); // R5
  AST_LOAD_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (rem_q == '0)); // R5
endmodule

// File: rtl/bmdma_addr.sv
module bmdma_addr #(
  parameter int unsigned MEM_BYTES = 32'h0100_0000,
  parameter int unsigned AW        = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [31:0]   base,
  output logic [AW-1:0] addr
);
  localparam bit POW2 = ((MEM_BYTES & (MEM_BYTES - 1)) == 0);

  logic [AW-1:0] addr_q, addr_d, base_m, inc;
  logic          upd_en;

  generate
    if (POW2) begin : g_pow2
      assign base_m = AW'((base & 32'hFFFF_FFFE) & 32'(MEM_BYTES - 1));
      assign inc    = addr_q + AW'(1);
    end else begin : g_mod
      assign base_m = AW'((base & 32'hFFFF_FFFE) % 32'(MEM_BYTES));
      assign inc    = (addr_q == AW'(MEM_BYTES - 1)) ? '0 : addr_q + AW'(1);
    end
  endgenerate

  always_comb begin
    upd_en = load | step;
    addr_d = load ? base_m : inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_q <= '0;
    else if (upd_en) addr_q <= addr_d;
  end

  assign addr = addr_q;

  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(addr_q) < MEM_BYTES); // R6
endmodule

// File: rtl/bmdma_ctrl.sv
module bmdma_ctrl
  import bmdma_pkg::*;
#(
  parameter int unsigned SECTOR_BYTES = 512,
  parameter int unsigned SEC_W        = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic             start_i,
  input  logic [SEC_W-1:0] secs_i,
  input  logic             dir_i,
  input  logic             desc_vld_i,
  input  logic             rgn_empty_i,
  input  logic             rgn_last_i,
  input  logic             rgn_eot_i,
  output logic             arm_take_o,
  output logic             fetch_o,
  output logic             load_o,
  output logic             beat_o,
  output logic             dir_o,
  output logic             active_o,
  output logic             done_o,
  output logic             fail_o
);
  localparam int unsigned SEC_FULL = 1 << SEC_W;
  localparam int unsigned OWED_W   = $clog2(SEC_FULL * SECTOR_BYTES + 1);

  bm_state_e         state_q, state_d;
  logic [OWED_W-1:0] owed_q, owed_d, req_len;
  logic              active_q, active_d;
  logic              dir_q, dir_d;
  logic              done_q, done_d;
  logic              fail_q, fail_d;
  logic              upd_en;

  assign req_len = (secs_i == '0) ? OWED_W'(SEC_FULL * SECTOR_BYTES)
                                  : OWED_W'(secs_i) * OWED_W'(SECTOR_BYTES);

  always_comb begin
    state_d    = state_q;
    owed_d     = owed_q;
    active_d   = active_q;
    dir_d      = dir_q;
    done_d     = 1'b0;
    fail_d     = 1'b0;
    arm_take_o = arm_i && (state_q == BM_IDLE);
    fetch_o    = (state_q == BM_FETCH);
    load_o     = fetch_o && desc_vld_i;
    beat_o     = (state_q == BM_MOVE);
    upd_en     = (state_q != BM_IDLE) || arm_i || start_i;
    case (state_q)
      BM_IDLE: begin
        if (arm_take_o) begin
          active_d = 1'b1;
        end else if (start_i) begin
          if (!active_q) begin
            fail_d = 1'b1;
          end else begin
            owed_d  = req_len;
            dir_d   = dir_i;
            state_d = rgn_empty_i ? BM_FETCH : BM_MOVE;
          end
        end
      end
      BM_FETCH: begin
        if (desc_vld_i) state_d = BM_MOVE;
      end
      BM_MOVE: begin
        owed_d = owed_q - OWED_W'(1);
        if (owed_q == OWED_W'(1)) begin
          state_d = BM_IDLE;
          done_d  = 1'b1;
          if (rgn_last_i && rgn_eot_i) active_d = 1'b0;
        end else if (rgn_last_i) begin
          if (rgn_eot_i) begin
            active_d = 1'b0;
            fail_d   = 1'b1;
            state_d  = BM_IDLE;
          end else begin
            state_d = BM_FETCH;
          end
        end
      end
      default: state_d = BM_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= BM_IDLE;
      owed_q   <= '0;
      active_q <= 1'b0;
      dir_q    <= 1'b0;
    end else if (upd_en) begin
      state_q  <= state_d;
      owed_q   <= owed_d;
      active_q <= active_d;
      dir_q    <= dir_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      done_q <= done_d;
      fail_q <= fail_d;
    end
  end

  assign dir_o    = dir_q;
  assign active_o = active_q;
  assign done_o   = done_q;
  assign fail_o   = fail_q;

  AST_DONE_FAIL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && fail_q)); // R9
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R9
  AST_FAIL_CLEARS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    fail_q |-> !active_q); // R8
  AST_BUSY_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != BM_IDLE) |-> active_q); // R2
  AST_OWED_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    beat_o |-> (owed_q != '0)); // R3
endmodule

// File: rtl/bmdma_engine.sv
module bmdma_engine #(
  parameter  int unsigned SECTOR_BYTES = 512,
  parameter  int unsigned MEM_BYTES    = 32'h0100_0000,
  parameter  int unsigned IDX_W        = 8,
  localparam int unsigned AW           = $clog2(MEM_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic             start_i,
  input  logic [7:0]       start_secs_i,
  input  logic             start_dir_i,
  output logic             desc_req_o,
  output logic [IDX_W-1:0] desc_idx_o,
  input  logic             desc_vld_i,
  input  logic [31:0]      desc_base_i,
  input  logic [15:0]      desc_cnt_i,
  input  logic             desc_eot_i,
  output logic             mem_we_o,
  output logic             mem_re_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [7:0]       mem_wdata_o,
  input  logic [7:0]       mem_rdata_i,
  output logic             dev_pop_o,
  input  logic [7:0]       dev_rdata_i,
  output logic             dev_push_o,
  output logic [7:0]       dev_wdata_o,
  output logic             active_o,
  output logic             done_o,
  output logic             fail_o
);
  logic rst_n_s;
  logic arm_take, fetch, load, beat, dir;
  logic rgn_empty, rgn_last, rgn_eot;

  bmdma_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  bmdma_ctrl #(
    .SECTOR_BYTES (SECTOR_BYTES),
    .SEC_W        (8)
  ) i_ctrl (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .arm_i       (arm_i),
    .start_i     (start_i),
    .secs_i      (start_secs_i),
    .dir_i       (start_dir_i),
    .desc_vld_i  (desc_vld_i),
    .rgn_empty_i (rgn_empty),
    .rgn_last_i  (rgn_last),
    .rgn_eot_i   (rgn_eot),
    .arm_take_o  (arm_take),
    .fetch_o     (fetch),
    .load_o      (load),
    .beat_o      (beat),
    .dir_o       (dir),
    .active_o    (active_o),
    .done_o      (done_o),
    .fail_o      (fail_o)
  );

  bmdma_region #(.IDX_W(IDX_W)) i_region (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .arm    (arm_take),
    .load   (load),
    .beat   (beat),
    .cnt    (desc_cnt_i),
    .eot_in (desc_eot_i),
    .idx    (desc_idx_o),
    .empty  (rgn_empty),
    .last   (rgn_last),
    .eot    (rgn_eot)
  );

  bmdma_addr #(
    .MEM_BYTES (MEM_BYTES),
    .AW        (AW)
  ) i_addr (
    .clk   (clk),
    .rst_n (rst_n_s),
    .load  (load),
    .step  (beat),
    .base  (desc_base_i),
    .addr  (mem_addr_o)
  );

  assign desc_req_o  = fetch;
  assign mem_we_o    = beat && dir;
  assign dev_pop_o   = beat && dir;
  assign mem_re_o    = beat && !dir;
  assign dev_push_o  = beat && !dir;
  assign mem_wdata_o = dev_rdata_i;
  assign dev_wdata_o = mem_rdata_i;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0({mem_we_o, mem_re_o})); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n_s)
    !active_o |-> !(mem_we_o || mem_re_o || desc_req_o)); // R2
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    (desc_req_o && !desc_vld_i) |=> desc_req_o); // R4
endmodule

// File: tb/test_bmdma_engine.sv
module test_bmdma_engine;
  localparam int CLK_PERIOD = 10;
  localparam int SB         = 4;
  localparam int MEMB       = 200;
  localparam int IW         = 4;
  localparam int AWB        = $clog2(MEMB);

  logic clk, rst_n;
  logic arm_i, start_i, start_dir_i;
  logic [7:0] start_secs_i;
  logic desc_req_o, desc_vld_i, desc_eot_i;
  logic [IW-1:0] desc_idx_o;
  logic [31:0] desc_base_i;
  logic [15:0] desc_cnt_i;
  logic mem_we_o, mem_re_o, dev_pop_o, dev_push_o;
  logic [AWB-1:0] mem_addr_o;
  logic [7:0] mem_wdata_o, mem_rdata_i, dev_rdata_i, dev_wdata_o;
  logic active_o, done_o, fail_o;

  bmdma_engine #(.SECTOR_BYTES(SB), .MEM_BYTES(MEMB), .IDX_W(IW)) i_bmdma_engine (
    .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .start_i(start_i),
    .start_secs_i(start_secs_i), .start_dir_i(start_dir_i),
    .desc_req_o(desc_req_o), .desc_idx_o(desc_idx_o), .desc_vld_i(desc_vld_i),
    .desc_base_i(desc_base_i), .desc_cnt_i(desc_cnt_i), .desc_eot_i(desc_eot_i),
    .mem_we_o(mem_we_o), .mem_re_o(mem_re_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .dev_pop_o(dev_pop_o), .dev_rdata_i(dev_rdata_i),
    .dev_push_o(dev_push_o), .dev_wdata_o(dev_wdata_o),
    .active_o(active_o), .done_o(done_o), .fail_o(fail_o)
  );

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  logic [31:0] t_base [0:15];
  logic [15:0] t_cnt  [0:15];
  logic        t_eot  [0:15];
  int          t_n;

  logic [7:0] mem [0:MEMB-1];
  int  g;          // beats since arm
  int  wr_seen;    // device pops seen since arm
  int  dev_cnt;    // device-side pop counter
  int  moved;
  bit  cur_dir;
  bit  act_model;

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  function automatic logic [7:0] pat(input int n);
    return 8'((n * 37 + 11) & 255);
  endfunction

  function automatic int rlen(input int k);
    return (t_cnt[k] == 16'd0) ? 65536 : int'(t_cnt[k]);
  endfunction

  function automatic int total();
    int s = 0;
    for (int k = 0; k < t_n; k++) s += rlen(k);
    return s;
  endfunction

  function automatic int exp_addr(input int gi);
    int k = 0;
    int off = gi;
    longint b;
    while (k < t_n - 1 && off >= rlen(k)) begin off -= rlen(k); k++; end
    b = longint'(t_base[k] & 32'hFFFF_FFFE) % MEMB;
    return int'((b + off) % MEMB);
  endfunction

  function automatic int fetches(input int g0, input int n);
    int c = 0;
    int cum = 0;
    for (int k = 0; k < t_n; k++) begin
      if (cum >= g0 && cum < g0 + n) c++;
      cum += rlen(k);
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  assign desc_base_i = t_base[desc_idx_o];
  assign desc_cnt_i  = t_cnt[desc_idx_o];
  assign desc_eot_i  = t_eot[desc_idx_o];
  assign mem_rdata_i = mem[mem_addr_o];
  assign dev_rdata_i = pat(dev_cnt);

  // synchronous models of memory and device source
  always @(posedge clk) begin
    if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
    if (arm_i) dev_cnt <= 0;
    else if (dev_pop_o) dev_cnt <= dev_cnt + 1;
  end

  // descriptor responder and beat monitor, away from the active edge
  always @(negedge clk) begin
    desc_vld_i <= desc_req_o;
    if (rst_n && (mem_we_o || mem_re_o)) begin
      int ea;
      ea = exp_addr(g);
      chk(int'(mem_addr_o) == ea, "R6 beat address", mem_addr_o, ea);
      chk(mem_we_o == cur_dir && dev_pop_o == mem_we_o && dev_push_o == mem_re_o,
          "R7 strobe direction", {mem_we_o, dev_pop_o, mem_re_o, dev_push_o}, cur_dir);
      if (mem_we_o) begin
        chk(mem_wdata_o == pat(wr_seen), "R7 write data", mem_wdata_o, pat(wr_seen));
        wr_seen++;
      end else begin
        chk(dev_wdata_o == mem[ea], "R7 read data", dev_wdata_o, mem[ea]);
      end
      g++;
      moved++;
    end
  end

  task automatic do_arm();
    @(negedge clk);
    arm_i = 1'b1;
    g = 0;
    wr_seen = 0;
    @(negedge clk);
    arm_i = 1'b0;
    act_model = 1'b1;
    chk(active_o == 1'b1, "R2 arm sets active", active_o, 1);
  endtask

  task automatic run(input int secs, input bit dir, input string tag);
    int req, tot, avail, eb, ef, lat;
    bit eok, eact;
    req = ((secs == 0) ? 256 : secs) * SB;
    tot = total();
    if (!act_model) begin
      eb = 0; ef = 0; eok = 1'b0; eact = 1'b0;
    end else begin
      avail = tot - g;
      eb    = (req < avail) ? req : avail;
      eok   = (req <= avail);
      ef    = fetches(g, eb);
      eact  = (g + eb) < tot;
    end
    moved   = 0;
    cur_dir = dir;
    @(negedge clk);
    start_secs_i = 8'(secs);
    start_dir_i  = dir;
    start_i      = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lat = 0;
    while (!(done_o || fail_o) && lat < 5000) begin
      @(negedge clk);
      lat++;
    end
    $display("  %s: secs=%0d dir=%0d bytes=%0d fetches=%0d", tag, secs, dir, eb, ef);
    chk(done_o == eok && fail_o == !eok, "R8/R3 outcome", {done_o, fail_o}, {eok, !eok});
    chk(lat == eb + ef, "R9 pulse latency", lat, eb + ef);
    chk(moved == eb, "R3/R5 bytes moved", moved, eb);
    chk(active_o == eact, "R8 active after request", active_o, eact);
    @(negedge clk);
    chk(!done_o && !fail_o, "R9 one-cycle pulse", {done_o, fail_o}, 0);
    act_model = eact;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    arm_i = 0; start_i = 0; start_secs_i = 0; start_dir_i = 0;
    g = 0; wr_seen = 0; moved = 0; cur_dir = 0; act_model = 0; dev_cnt = 0;
    for (int a = 0; a < MEMB; a++) mem[a] = 8'(a ^ 8'h5A);
    for (int k = 0; k < 16; k++) begin t_base[k] = 0; t_cnt[k] = 1; t_eot[k] = 1; end
    t_n = 1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(active_o == 0, "R1 active low", active_o, 0);
    chk(!desc_req_o && !mem_we_o && !mem_re_o && !dev_pop_o && !dev_push_o,
        "R1 strobes low", {desc_req_o, mem_we_o, mem_re_o, dev_pop_o, dev_push_o}, 0);
    chk(!done_o && !fail_o, "R1 pulses low", {done_o, fail_o}, 0);

    // R2 start while inactive
    run(1, 1'b1, "R2 inactive start");

    // R4 R5 R3 regions spanning wrap, odd base, zero count = 65536
    t_base[0] = 32'd195;  t_cnt[0] = 16'd9; t_eot[0] = 1'b0;
    t_base[1] = 32'd61;   t_cnt[1] = 16'd5; t_eot[1] = 1'b0;
    t_base[2] = 32'd1010; t_cnt[2] = 16'd0; t_eot[2] = 1'b1;
    t_n = 3;
    do_arm();
    for (int s = 1; s <= 6; s++) run(s, 1'(s % 2), "R5 sweep A");
    run(0, 1'b1, "R3 zero sectors write");
    run(0, 1'b0, "R3 zero sectors read");

    // R8 table runs out while bytes are owed
    t_base[0] = 32'd20; t_cnt[0] = 16'd6; t_eot[0] = 1'b0;
    t_base[1] = 32'd41; t_cnt[1] = 16'd3; t_eot[1] = 1'b1;
    t_n = 2;
    do_arm();
    run(3, 1'b1, "R8 short table");
    run(1, 1'b0, "R2 after exhaustion");

    // R8 transfer ends exactly on the last region
    t_base[0] = 32'd150; t_cnt[0] = 16'd8; t_eot[0] = 1'b1;
    t_n = 1;
    do_arm();
    run(2, 1'b0, "R8 exact end");
    run(1, 1'b1, "R2 after exact end");

    // R6 R5 sweep of small regions with scattered bases
    for (int k = 0; k < 8; k++) begin
      t_base[k] = 32'(k * 53 + 7);
      t_cnt[k]  = 16'(k + 1);
      t_eot[k]  = (k == 7);
    end
    t_n = 8;
    do_arm();
    for (int r = 0; r < 10; r++) run(1, 1'(r % 2), "R6 sweep D");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule